// File: doc/BRIEF.md
# Indirect Configuration Access Port

This block gives a host processor an indirect path into configuration space. The host first writes a 32-bit target address into a pointer register. The address names a bus, a device, a function and a dword register. The host then reads or writes a four-byte data window, and the block turns each of those accesses into one configuration request on a request/completion interface. The request carries the decoded target fields, four byte enables and the write data already placed in its byte lanes.

The same host port also reaches a local register block that starts at offset 0x80000. Its first 64 bytes hold a writable copy of the bridge's own configuration header, arranged as little-endian 32-bit words. The data window does not check the pointer's enable bit (bit 31), so software that never sets it still reaches its targets. The low two bits of the window offset are ORed into the pointer's low bits to choose the starting byte.

Host traffic uses a valid/ready request and a valid/ready response. The block holds one access at a time. `hst_ready` is low from the edge that accepts an access until the edge where the response is taken. A response stays on `rsp_valid` with stable data until `rsp_ready` is seen. On the configuration side a request stays on `cfg_req_valid` with stable fields until `cfg_req_ready`. A read then waits for `cfg_cpl_valid`.

Top module: `pcfg_port`

## Requirements
- R1: After reset the pointer register reads 0, header word 0 reads the parameter ID_WORD, header word 2 reads CLASS_WORD, `hst_ready` is 1 and `cfg_req_valid` is 0.
- R2: Offsets 0x0–0x3 access the pointer register with byte-lane writes. Its fields drive `cfg_bus` from bits [23:16], `cfg_dev` from [15:11], `cfg_fn` from [10:8] and `cfg_reg` from [7:2].
- R3: An access to offsets 0x4–0x7 forwards one request. Its byte offset is pointer[1:0] OR hst_addr[1:0]. `cfg_be` is the width mask (size code 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes) shifted left by that offset, and lanes above 3 are dropped.
- R4: Window accesses are forwarded whether pointer bit 31 is 1 or 0.
- R5: Write data, taken right-justified from `hst_wdata`, goes out on `cfg_wdata` shifted left by 8×offset. Read data returns `cfg_cpl_data` shifted right by 8×offset and masked to the access width. The same lane rules apply to local reads and writes, using hst_addr[1:0] as the offset.
- R6: `cfg_req_valid` and its fields stay stable until `cfg_req_ready`. A write responds in the cycle after the request is accepted, with rdata 0. A read responds only after `cfg_cpl_valid`.
- R7: Only one access is outstanding. `hst_ready` is 0 from acceptance until the response is taken. `rsp_valid` and `rsp_rdata` hold until `rsp_ready`. Every write response carries rdata 0.
- R8: Offsets 0x80000–0x8003F read and write the 16-word header copy with byte lanes, little-endian.
- R9: Any other offset reads 0, accepts writes without changing any state, and issues no configuration request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_valid | input | 1 | Host access valid |
| hst_ready | output | 1 | Block can accept an access |
| hst_write | input | 1 | 1 = write, 0 = read |
| hst_addr | input | ADDR_W | Byte offset of the access |
| hst_size | input | 2 | Width code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| hst_wdata | input | 32 | Right-justified write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 32 | Right-justified read data, 0 for writes |
| cfg_req_valid | output | 1 | Configuration request valid |
| cfg_req_ready | input | 1 | Target accepts the request |
| cfg_write | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_reg | output | 6 | Target dword register |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_cpl_valid | input | 1 | Read completion valid |
| cfg_cpl_data | input | 32 | Completion dword |

## Verification
The hardest case is a start byte formed by ORing nonzero pointer low bits with the window offset, so that a wide access runs off lane 3. The bench reaches it by first writing a pointer with bit 0 set, then making 1-byte and 4-byte window accesses at offset 0x6 and 0x4. It also holds back `cfg_req_ready`, the completion and `rsp_ready` for several cycles, so that the hold-and-stable rules are checked while the block is stalled.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CREQ,
    ST_CWAIT,
    ST_RESP
  } pcfg_state_t;

  typedef enum logic [1:0] {
    RG_PTR,
    RG_WIN,
    RG_HDR,
    RG_NONE
  } pcfg_rgn_t;

  // width code -> byte mask before shifting
  function automatic logic [3:0] width_lanes(input logic [1:0] sz);
    case (sz)
      2'd0:    width_lanes = 4'b0001;
      2'd1:    width_lanes = 4'b0011;
      default: width_lanes = 4'b1111;
    endcase
  endfunction

  function automatic logic [3:0] lane_en(input logic [1:0] sz, input logic [1:0] off);
    logic [6:0] m;
    m = {3'b000, width_lanes(sz)} << off;
    lane_en = m[3:0];
  endfunction

  function automatic logic [31:0] width_mask(input logic [1:0] sz);
    logic [3:0] l;
    l = width_lanes(sz);
    width_mask = {{8{l[3]}}, {8{l[2]}}, {8{l[1]}}, {8{l[0]}}};
  endfunction

endpackage

// File: rtl/pcfg_lanes.sv
module pcfg_lanes
  import pcfg_pkg::*;
(
  input  logic [1:0]  sz,
  input  logic [1:0]  off,
  input  logic [31:0] wd_right,
  input  logic [31:0] rword,
  output logic [3:0]  be,
  output logic [31:0] wd_lane,
  output logic [31:0] rd_right
);
  logic [4:0] sh;

  always_comb begin
    sh       = {off, 3'b000};
    be       = lane_en(sz, off);
    wd_lane  = wd_right << sh;
    rd_right = (rword >> sh) & width_mask(sz);
  end
endmodule

// File: rtl/pcfg_ptr_reg.sv
module pcfg_ptr_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W/8-1:0] be,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  localparam int unsigned NB = W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)               q[8*b +: 8] <= '0;
      else if (we && be[b])     q[8*b +: 8] <= wd[8*b +: 8];
    end
  end

  // R2: pointer only changes through an accepted write
  p_ptr_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/pcfg_hdr_mirror.sv
module pcfg_hdr_mirror #(
  parameter int unsigned  HDR_BYTES  = 64,
  parameter logic [31:0]  ID_WORD    = 32'h7C01_1AF4,
  parameter logic [31:0]  CLASS_WORD = 32'h0604_0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [$clog2(HDR_BYTES/4)-1:0] idx,
  input  logic [3:0]   be,
  input  logic [31:0]  wd,
  output logic [31:0]  rdata
);
  localparam int unsigned NWORDS = HDR_BYTES / 4;

  logic [31:0] words [NWORDS];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam logic [31:0] INIT = (w == 0) ? ID_WORD :
                                   (w == 2) ? CLASS_WORD : 32'h0;
    for (genvar b = 0; b < 4; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (!rst_n)
          words[w][8*b +: 8] <= INIT[8*b +: 8];
        else if (we && be[b] && (idx == w[$clog2(NWORDS)-1:0]))
          words[w][8*b +: 8] <= wd[8*b +: 8];
      end
    end
  end

  assign rdata = words[idx];

  // R8: a selected word is untouched when no write is issued
  p_hdr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(words[0]) && $stable(words[NWORDS-1]));
endmodule

// File: rtl/pcfg_port.sv
module pcfg_port
  import pcfg_pkg::*;
#(
  parameter int unsigned  ADDR_W     = 20,
  parameter int unsigned  REG_BASE   = 32'h8_0000,
  parameter int unsigned  HDR_BYTES  = 64,
  parameter int unsigned  WIN_OFS    = 4,
  parameter logic [31:0]  ID_WORD    = 32'h7C01_1AF4,
  parameter logic [31:0]  CLASS_WORD = 32'h0604_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_valid,
  output logic              hst_ready,
  input  logic              hst_write,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [1:0]        hst_size,
  input  logic [31:0]       hst_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              cfg_req_valid,
  input  logic              cfg_req_ready,
  output logic              cfg_write,
  output logic [7:0]        cfg_bus,
  output logic [4:0]        cfg_dev,
  output logic [2:0]        cfg_fn,
  output logic [5:0]        cfg_reg,
  output logic [3:0]        cfg_be,
  output logic [31:0]       cfg_wdata,
  input  logic              cfg_cpl_valid,
  input  logic [31:0]       cfg_cpl_data
);
  localparam int unsigned IDX_W = $clog2(HDR_BYTES / 4);
  localparam logic [ADDR_W-1:0] HDR_LO = ADDR_W'(REG_BASE);
  localparam logic [ADDR_W-1:0] HDR_HI = ADDR_W'(REG_BASE + HDR_BYTES);
  localparam logic [ADDR_W-3:0] PTR_WORD = '0;
  localparam logic [ADDR_W-3:0] WIN_WORD = (ADDR_W-2)'(WIN_OFS / 4);

  pcfg_state_t st_q;
  pcfg_rgn_t   rgn;
  logic        accept;
  logic [31:0] ptr_q, hdr_rd, local_word, rdata_q;
  logic [3:0]  be_h, be_c;
  logic [31:0] wl_h, rj_h, wl_c, rj_c;
  logic [1:0]  off_q, sz_q;
  logic [31:0] wd_q;
  logic        wr_q;

  // ---------------- decode ----------------
  always_comb begin
    if (hst_addr[ADDR_W-1:2] == PTR_WORD)               rgn = RG_PTR;
    else if (hst_addr[ADDR_W-1:2] == WIN_WORD)          rgn = RG_WIN;
    else if (hst_addr >= HDR_LO && hst_addr < HDR_HI)   rgn = RG_HDR;
    else                                                rgn = RG_NONE;
  end

  assign hst_ready = (st_q == ST_IDLE);
  assign accept    = hst_valid && hst_ready;

  always_comb begin
    case (rgn)
      RG_PTR:  local_word = ptr_q;
      RG_HDR:  local_word = hdr_rd;
      default: local_word = '0;
    endcase
  end

  // lane handling for local accesses (live inputs)
  pcfg_lanes u_lane_h (
    .sz(hst_size), .off(hst_addr[1:0]), .wd_right(hst_wdata), .rword(local_word),
    .be(be_h), .wd_lane(wl_h), .rd_right(rj_h)
  );

  pcfg_ptr_reg #(.W(32)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .we(accept && hst_write && (rgn == RG_PTR)),
    .be(be_h), .wd(wl_h), .q(ptr_q)
  );

  pcfg_hdr_mirror #(.HDR_BYTES(HDR_BYTES), .ID_WORD(ID_WORD), .CLASS_WORD(CLASS_WORD)) u_hdr (
    .clk(clk), .rst_n(rst_n),
    .we(accept && hst_write && (rgn == RG_HDR)),
    .idx(hst_addr[IDX_W+1:2]), .be(be_h), .wd(wl_h), .rdata(hdr_rd)
  );

  // lane handling for forwarded accesses (latched)
  pcfg_lanes u_lane_c (
    .sz(sz_q), .off(off_q), .wd_right(wd_q), .rword(cfg_cpl_data),
    .be(be_c), .wd_lane(wl_c), .rd_right(rj_c)
  );

  // ---------------- sequencing ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      rdata_q <= '0;
      off_q   <= '0;
      sz_q    <= '0;
      wd_q    <= '0;
      wr_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          if (rgn == RG_WIN) begin
            off_q <= ptr_q[1:0] | hst_addr[1:0];
            sz_q  <= hst_size;
            wd_q  <= hst_wdata;
            wr_q  <= hst_write;
            st_q  <= ST_CREQ;
          end else begin
            rdata_q <= hst_write ? 32'h0 : rj_h;
            st_q    <= ST_RESP;
          end
        end
        ST_CREQ: if (cfg_req_ready) begin
          if (wr_q) begin
            rdata_q <= '0;
            st_q    <= ST_RESP;
          end else begin
            st_q    <= ST_CWAIT;
          end
        end
        ST_CWAIT: if (cfg_cpl_valid) begin
          rdata_q <= rj_c;
          st_q    <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid     = (st_q == ST_RESP);
  assign rsp_rdata     = rdata_q;
  assign cfg_req_valid = (st_q == ST_CREQ);
  assign cfg_write     = wr_q;
  assign cfg_be        = be_c;
  assign cfg_wdata     = wl_c;
  assign cfg_bus       = ptr_q[23:16];
  assign cfg_dev       = ptr_q[15:11];
  assign cfg_fn        = ptr_q[10:8];
  assign cfg_reg       = ptr_q[7:2];

  // ---------------- assertions ----------------
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && !cfg_req_ready |=>
      cfg_req_valid && $stable(cfg_be) && $stable(cfg_wdata) && $stable(cfg_write)
      && $stable(cfg_reg) && $stable(cfg_bus));

  p_wr_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && cfg_req_ready && cfg_write |=> rsp_valid && (rsp_rdata == 32'h0));

  p_rd_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid && cfg_req_ready && !cfg_write |=> !rsp_valid);

  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  p_one_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hst_valid && hst_ready |=> !hst_ready);

  p_no_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hst_valid && hst_ready && (rgn == RG_NONE) |=> !cfg_req_valid);
endmodule

// File: tb/sim_pcfg_port.sv
module sim_pcfg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_valid = 1'b0, hst_write = 1'b0;
  logic [19:0] hst_addr = '0;
  logic [1:0]  hst_size = '0;
  logic [31:0] hst_wdata = '0;
  logic        rsp_ready = 1'b0;
  logic        cfg_req_ready = 1'b0, cfg_cpl_valid = 1'b0;
  logic [31:0] cfg_cpl_data = '0;
  logic        hst_ready, rsp_valid, cfg_req_valid, cfg_write;
  logic [31:0] rsp_rdata, cfg_wdata;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [5:0]  cfg_reg;
  logic [3:0]  cfg_be;

  localparam logic [31:0] ID_W = 32'h7C01_1AF4;
  localparam logic [31:0] CL_W = 32'h0604_0001;

  pcfg_port u0 (.*);

  always #10 clk = ~clk;  // 50 MHz

  int n_chk = 0, n_bad = 0;
  int stall = 0, cpl_lat = 1, rsp_hold = 0, n_reqs = 0, stab_bad = 0;
  logic [31:0] tgt_data = '0;
  logic [3:0]  c_be;
  logic [31:0] c_wd;
  logic        c_wr;
  logic [5:0]  c_reg;
  logic [7:0]  c_bus;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // configuration target model
  initial begin
    forever begin
      @(negedge clk);
      if (cfg_req_valid) begin
        c_be = cfg_be; c_wd = cfg_wdata; c_wr = cfg_write; c_reg = cfg_reg; c_bus = cfg_bus;
        for (int i = 0; i < stall; i++) begin
          @(negedge clk);
          if (!cfg_req_valid || cfg_be !== c_be || cfg_wdata !== c_wd || cfg_write !== c_wr)
            stab_bad++;
        end
        cfg_req_ready = 1'b1;
        @(negedge clk);
        cfg_req_ready = 1'b0;
        n_reqs++;
        if (!c_wr) begin
          for (int i = 1; i < cpl_lat; i++) @(negedge clk);
          cfg_cpl_valid = 1'b1; cfg_cpl_data = tgt_data;
          @(negedge clk);
          cfg_cpl_valid = 1'b0;
        end
      end
    end
  end

  task automatic host_op(input bit wr, input logic [19:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, output logic [31:0] rd);
    bit seen;
    int hold_bad;
    logic [31:0] first;
    hold_bad = 0;
    @(negedge clk);
    hst_valid = 1'b1; hst_write = wr; hst_addr = a; hst_size = sz; hst_wdata = wd;
    do begin
      seen = hst_ready;
      @(posedge clk);
    end while (!seen);
    @(negedge clk);
    hst_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    first = rsp_rdata;
    for (int i = 0; i < rsp_hold; i++) begin
      if (!rsp_valid || hst_ready || rsp_rdata !== first) hold_bad++;
      @(negedge clk);
    end
    if (rsp_hold > 0) check("R7 response held", hold_bad, 0);
    rd = rsp_rdata;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] r;
    check("R1 hst_ready", {31'b0, hst_ready}, 1);
    check("R1 cfg_req_valid", {31'b0, cfg_req_valid}, 0);
    host_op(0, 20'h00000, 2, 0, r); check("R1 pointer", r, 0);
    host_op(0, 20'h80000, 2, 0, r); check("R1 header id", r, ID_W);
    host_op(0, 20'h80008, 2, 0, r); check("R1 header class", r, CL_W);
  endtask

  task automatic t_pointer;
    logic [31:0] r;
    host_op(1, 20'h00000, 2, 32'h8012_AB5C, r);
    check("R2 bus", {24'b0, cfg_bus}, 32'h12);
    check("R2 dev", {27'b0, cfg_dev}, 32'h15);
    check("R2 fn", {29'b0, cfg_fn}, 3);
    check("R2 reg", {26'b0, cfg_reg}, 32'h17);
    host_op(0, 20'h00000, 2, 0, r); check("R2 readback", r, 32'h8012_AB5C);
    host_op(1, 20'h00002, 0, 32'h34, r);
    host_op(0, 20'h00000, 2, 0, r); check("R2 byte write", r, 32'h8034_AB5C);
    check("R2 bus after byte", {24'b0, cfg_bus}, 32'h34);
    host_op(0, 20'h00001, 0, 0, r); check("R5 byte read", r, 32'hAB);
  endtask

  task automatic t_win_write;
    logic [31:0] r;
    int n0;
    n0 = n_reqs;
    host_op(1, 20'h00004, 2, 32'hDEAD_BEEF, r);
    check("R3 be word", {28'b0, c_be}, 4'hF);
    check("R5 wdata word", c_wd, 32'hDEAD_BEEF);
    check("R6 write rsp zero", r, 0);
    host_op(1, 20'h00006, 0, 32'h5A, r);
    check("R3 be byte2", {28'b0, c_be}, 4'b0100);
    check("R5 wdata byte2", c_wd, 32'h005A_0000);
    host_op(1, 20'h00007, 1, 32'h1234, r);
    check("R3 be clipped", {28'b0, c_be}, 4'b1000);
    check("R5 wdata clipped", c_wd, 32'h3400_0000);
    check("R4 forwarded with enable", n_reqs - n0, 3);
  endtask

  task automatic t_enable_clear;
    logic [31:0] r;
    int n0;
    host_op(1, 20'h00000, 2, 32'h0001_0008, r);
    n0 = n_reqs;
    tgt_data = 32'hCAFE_F00D;
    host_op(0, 20'h00006, 1, 0, r);
    check("R4 forwarded without enable", n_reqs - n0, 1);
    check("R5 half read", r, 32'hCAFE);
    check("R3 be half", {28'b0, c_be}, 4'b1100);
    check("R2 reg field", {26'b0, c_reg}, 2);
    check("R2 bus field", {24'b0, c_bus}, 1);
  endtask

  task automatic t_or_bits;
    logic [31:0] r;
    host_op(1, 20'h00000, 2, 32'h0000_0001, r);
    tgt_data = 32'h1122_3344;
    host_op(0, 20'h00006, 0, 0, r);
    check("R3 or offset be", {28'b0, c_be}, 4'b1000);
    check("R5 or offset data", r, 32'h11);
    host_op(0, 20'h00004, 2, 0, r);
    check("R3 or word be", {28'b0, c_be}, 4'b1110);
    check("R5 or word data", r, 32'h0011_2233);
  endtask

  task automatic t_stall;
    logic [31:0] r;
    host_op(1, 20'h00000, 2, 32'h0000_0000, r);
    stall = 3; cpl_lat = 4; stab_bad = 0;
    tgt_data = 32'h0BAD_F00D;
    host_op(0, 20'h00004, 2, 0, r);
    check("R6 read after delayed cpl", r, 32'h0BAD_F00D);
    host_op(1, 20'h00004, 2, 32'h600D_0001, r);
    check("R6 write after stall", c_wd, 32'h600D_0001);
    check("R6 request stable", stab_bad, 0);
    stall = 0; cpl_lat = 1;
  endtask

  task automatic t_rsp_hold;
    logic [31:0] r;
    rsp_hold = 3;
    host_op(0, 20'h80000, 2, 0, r); check("R7 held read data", r, ID_W);
    host_op(1, 20'h80004, 2, 32'h1, r); check("R7 write rdata zero", r, 0);
    rsp_hold = 0;
  endtask

  task automatic t_header;
    logic [31:0] r;
    host_op(1, 20'h80010, 2, 32'h0102_0304, r);
    host_op(1, 20'h80011, 0, 32'hEE, r);
    host_op(0, 20'h80010, 2, 0, r); check("R8 byte merge", r, 32'h0102_EE04);
    host_op(0, 20'h80012, 1, 0, r); check("R8 half read", r, 32'h0102);
    host_op(1, 20'h8003C, 2, 32'hA5A5_5A5A, r);
    host_op(0, 20'h8003C, 2, 0, r); check("R8 last word", r, 32'hA5A5_5A5A);
  endtask

  task automatic t_other;
    logic [31:0] r;
    int n0;
    host_op(1, 20'h00000, 2, 32'h0055_0000, r);
    n0 = n_reqs;
    host_op(1, 20'h80040, 2, 32'hFFFF_FFFF, r);
    host_op(0, 20'h80040, 2, 0, r); check("R9 past header", r, 0);
    host_op(1, 20'h00010, 2, 32'hFFFF_FFFF, r);
    host_op(0, 20'h00010, 2, 0, r); check("R9 hole", r, 0);
    host_op(0, 20'h80000, 2, 0, r); check("R9 header intact", r, ID_W);
    host_op(0, 20'h00000, 2, 0, r); check("R9 pointer intact", r, 32'h0055_0000);
    check("R9 no request", n_reqs - n0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pointer();
    t_win_write();
    t_enable_clear();
    t_or_bits();
    t_stall();
    t_rsp_hold();
    t_header();
    t_other();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule